// File: doc/BRIEF.md
# Soft-Switched Leg Hysteresis Current Controller

This block decides, on every control clock, when the two switches of one soft-switched half-bridge leg open and close. Its inputs are a signed sample of the inductor current, a signed current set-point, a threshold current, a signed estimate of the inductor-current slope, and two flags that report when each switch's antiparallel diode conducts. It drives the high-side and low-side gate commands.

The turn-off levels follow the sign of the set-point, so that the average inductor current tracks the set-point. The threshold stays on the opposite side of zero, which leaves enough reverse current to swing the switching node. A switch opens only when the current is large enough to commutate the node. A switch closes only after its own diode has taken the current. While one gate has dropped and the other has not yet risen, both gates are low.

When the output voltage sits on a supply rail, the current can stop moving toward the level. A slope criterion then forces the conducting switch off, so the leg keeps switching.

Top module: `zvs_hcc`

## Requirements
- R1: While reset is asserted both gates are low. After reset the controller waits for the low-side diode flag before it closes any switch.
- R2: For a set-point of zero or more, the upper level is 2·set + thr and the lower level is −thr. Here thr is the effective threshold defined in R4.
- R3: For a negative set-point, the upper level is thr and the lower level is 2·set − thr.
- R4: The level arithmetic saturates to the 16-bit signed range [−32768, 32767] and never wraps. A negative threshold input is treated as zero.
- R5: With the high-side gate on, a sample at or above the upper level turns the high side off at the next clock edge.
- R6: With the low-side gate on, a sample at or below the lower level turns the low side off at the next clock edge.
- R7: The high side never turns off while the current is below thr. The low side never turns off while the current is above −thr. This guard applies to both the level criterion and the slope criterion.
- R8: With the high side on, a slope of zero or less turns the high side off once the current is at or above thr, even if the upper level has not been reached.
- R9: With the low side on, a slope of zero or more turns the low side off once the current is at or below −thr.
- R10: A gate rises only one clock after its own diode flag was seen high while the controller was waiting for it. The other diode flag has no effect.
- R11: The two gates are never high together. After either gate falls, both gates are low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_meas | input | 16 | Sampled inductor current, two's complement |
| cur_set | input | 16 | Current set-point, two's complement |
| cur_thr | input | 16 | Threshold / minimum commutation current; negative values are treated as zero |
| cur_slope | input | 16 | Inductor-current slope estimate, two's complement |
| hs_diode_on | input | 1 | High-side antiparallel diode conducts |
| ls_diode_on | input | 1 | Low-side antiparallel diode conducts |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The bench builds the block with its default 16-bit data width. At that width, set-points of ±30000 combined with a threshold of 10000 drive both levels past the representable range, so the saturation points 32767 and −32768 can be hit exactly. Exact level boundaries are approached one count at a time for both set-point signs. The slope criterion is checked at a slope of exactly zero and at a current just inside the commutation guard. A negative threshold is driven, and its treatment as zero is observed through where the gates switch.

// File: rtl/zvs_hcc_pkg.sv
package zvs_hcc_pkg;

  // Leg phase: which switch conducts, or which diode is awaited.
  typedef enum logic [1:0] {
    PH_HIGH_ON = 2'd0,
    PH_WAIT_LO = 2'd1,
    PH_LOW_ON  = 2'd2,
    PH_WAIT_HI = 2'd3
  } leg_phase_t;

endpackage

// File: rtl/zvs_hcc_levels.sv
// Turn-off level computation with saturation (R2, R3, R4).
module zvs_hcc_levels #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] cur_set,
  input  logic signed [W-1:0] cur_thr,
  output logic signed [W-1:0] thr_eff,
  output logic signed [W-1:0] lvl_hi,
  output logic signed [W-1:0] lvl_lo
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] MAX_X = $signed({{(EW-W+1){1'b0}}, {(W-1){1'b1}}});
  localparam logic signed [EW-1:0] MIN_X = $signed({{(EW-W+1){1'b1}}, {(W-1){1'b0}}});

  function automatic logic signed [W-1:0] sat_w(input logic signed [EW-1:0] v);
    if (v > MAX_X)      return MAX_X[W-1:0];
    else if (v < MIN_X) return MIN_X[W-1:0];
    else                return v[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] clamp_thr(input logic signed [W-1:0] t);
    return t[W-1] ? '0 : t;
  endfunction

  logic signed [EW-1:0] set_x2;
  logic signed [EW-1:0] thr_x;
  logic signed [EW-1:0] up_raw;
  logic signed [EW-1:0] dn_raw;
  logic                 set_neg;

  assign thr_eff = clamp_thr(cur_thr);
  assign set_neg = cur_set[W-1];
  assign set_x2  = $signed({cur_set[W-1], cur_set[W-1], cur_set}) <<< 1;
  assign thr_x   = $signed({2'b00, thr_eff});
  assign up_raw  = set_x2 + thr_x;
  assign dn_raw  = set_x2 - thr_x;

  always_comb begin
    if (set_neg) begin
      lvl_hi = thr_eff;
      lvl_lo = sat_w(dn_raw);
    end else begin
      lvl_hi = sat_w(up_raw);
      lvl_lo = '0 - thr_eff;
    end
  end
endmodule

// File: rtl/zvs_hcc_offrule.sv
// Turn-off decision for one switch; HIGH_SIDE picks the polarity (R5-R9).
module zvs_hcc_offrule #(
  parameter int W = 16,
  parameter bit HIGH_SIDE = 1'b1
) (
  input  logic                active,
  input  logic signed [W-1:0] cur_meas,
  input  logic signed [W-1:0] cur_slope,
  input  logic signed [W-1:0] level,
  input  logic signed [W-1:0] thr_eff,
  output logic                level_hit,
  output logic                slope_hit,
  output logic                commute_ok,
  output logic                turn_off
);
  logic signed [W:0] meas_x;
  logic signed [W:0] neg_thr;
  logic              slope_zero;

  assign meas_x     = $signed({cur_meas[W-1], cur_meas});
  assign neg_thr    = -$signed({1'b0, thr_eff});
  assign slope_zero = (cur_slope == '0);

  generate
    if (HIGH_SIDE) begin : g_high
      assign level_hit  = (cur_meas >= level);
      assign slope_hit  = cur_slope[W-1] || slope_zero;
      assign commute_ok = (cur_meas >= thr_eff);
    end else begin : g_low
      assign level_hit  = (cur_meas <= level);
      assign slope_hit  = !cur_slope[W-1];
      assign commute_ok = (meas_x <= neg_thr);
    end
  endgenerate

  assign turn_off = active && commute_ok && (level_hit || slope_hit);
endmodule

// File: rtl/zvs_hcc_seq.sv
// Four-phase leg sequencer (R1, R10, R11).
module zvs_hcc_seq
  import zvs_hcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic off_hi,
  input  logic off_lo,
  input  logic hs_diode_on,
  input  logic ls_diode_on,
  output logic hs_gate,
  output logic ls_gate
);
  leg_phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_HIGH_ON: if (off_hi)      ph_d = PH_WAIT_LO;
      PH_WAIT_LO: if (ls_diode_on) ph_d = PH_LOW_ON;
      PH_LOW_ON:  if (off_lo)      ph_d = PH_WAIT_HI;
      PH_WAIT_HI: if (hs_diode_on) ph_d = PH_HIGH_ON;
      default:                     ph_d = PH_WAIT_LO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_WAIT_LO;
    else        ph_q <= ph_d;
  end

  assign hs_gate = (ph_q == PH_HIGH_ON);
  assign ls_gate = (ph_q == PH_LOW_ON);
endmodule

// File: rtl/zvs_hcc.sv
// Hysteresis current controller for one soft-switched half-bridge leg.
module zvs_hcc #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] cur_meas,
  input  logic signed [W-1:0] cur_set,
  input  logic signed [W-1:0] cur_thr,
  input  logic signed [W-1:0] cur_slope,
  input  logic                hs_diode_on,
  input  logic                ls_diode_on,
  output logic                hs_gate,
  output logic                ls_gate
);
  // Internal events brought out for the checker.
  logic signed [W-1:0] thr_eff;
  logic signed [W-1:0] lvl_hi;
  logic signed [W-1:0] lvl_lo;
  logic hi_level_hit, hi_slope_hit, hi_commute_ok, hi_off;
  logic lo_level_hit, lo_slope_hit, lo_commute_ok, lo_off;

  zvs_hcc_levels #(.W(W)) u_levels (
    .cur_set (cur_set),
    .cur_thr (cur_thr),
    .thr_eff (thr_eff),
    .lvl_hi  (lvl_hi),
    .lvl_lo  (lvl_lo)
  );

  zvs_hcc_offrule #(.W(W), .HIGH_SIDE(1'b1)) u_off_hi (
    .active     (hs_gate),
    .cur_meas   (cur_meas),
    .cur_slope  (cur_slope),
    .level      (lvl_hi),
    .thr_eff    (thr_eff),
    .level_hit  (hi_level_hit),
    .slope_hit  (hi_slope_hit),
    .commute_ok (hi_commute_ok),
    .turn_off   (hi_off)
  );

  zvs_hcc_offrule #(.W(W), .HIGH_SIDE(1'b0)) u_off_lo (
    .active     (ls_gate),
    .cur_meas   (cur_meas),
    .cur_slope  (cur_slope),
    .level      (lvl_lo),
    .thr_eff    (thr_eff),
    .level_hit  (lo_level_hit),
    .slope_hit  (lo_slope_hit),
    .commute_ok (lo_commute_ok),
    .turn_off   (lo_off)
  );

  zvs_hcc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .off_hi      (hi_off),
    .off_lo      (lo_off),
    .hs_diode_on (hs_diode_on),
    .ls_diode_on (ls_diode_on),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate)
  );
endmodule

// File: rtl/zvs_hcc_checker.sv
module zvs_hcc_checker #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic signed [W-1:0] cur_meas,
  input logic signed [W-1:0] cur_slope,
  input logic                hs_diode_on,
  input logic                ls_diode_on,
  input logic                hs_gate,
  input logic                ls_gate,
  input logic signed [W-1:0] thr_eff,
  input logic signed [W-1:0] lvl_hi,
  input logic signed [W-1:0] lvl_lo,
  input logic                hi_level_hit,
  input logic                hi_slope_hit,
  input logic                hi_commute_ok,
  input logic                lo_level_hit,
  input logic                lo_slope_hit,
  input logic                lo_commute_ok
);
  logic slope_le0, slope_ge0;
  assign slope_le0 = cur_slope[W-1] || (cur_slope == '0);
  assign slope_ge0 = !cur_slope[W-1];

  assert_gates_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_dead_after_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> !ls_gate);

  assert_dead_after_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_gate) |-> !hs_gate);

  assert_hi_on_diode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(hs_diode_on));

  assert_lo_on_diode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(ls_diode_on));

  assert_level_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hi >= lvl_lo);

  assert_hi_commute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> ($past(cur_meas) >= $past(thr_eff)));

  assert_lo_commute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_gate) |-> ($past(cur_meas) <= -$past(thr_eff)));

  assert_hi_level_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && cur_meas >= lvl_hi) |=> !hs_gate);

  assert_lo_level_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && cur_meas <= lvl_lo) |=> !ls_gate);

  assert_hi_slope_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && slope_le0 && cur_meas >= thr_eff) |=> !hs_gate);

  assert_lo_slope_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && slope_ge0 && cur_meas <= -thr_eff) |=> !ls_gate);

  assert_hi_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> $past(hi_commute_ok && (hi_level_hit || hi_slope_hit)));

  assert_lo_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_gate) |-> $past(lo_commute_ok && (lo_level_hit || lo_slope_hit)));
endmodule

bind zvs_hcc zvs_hcc_checker #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cur_meas      (cur_meas),
  .cur_slope     (cur_slope),
  .hs_diode_on   (hs_diode_on),
  .ls_diode_on   (ls_diode_on),
  .hs_gate       (hs_gate),
  .ls_gate       (ls_gate),
  .thr_eff       (thr_eff),
  .lvl_hi        (lvl_hi),
  .lvl_lo        (lvl_lo),
  .hi_level_hit  (hi_level_hit),
  .hi_slope_hit  (hi_slope_hit),
  .hi_commute_ok (hi_commute_ok),
  .lo_level_hit  (lo_level_hit),
  .lo_slope_hit  (lo_slope_hit),
  .lo_commute_ok (lo_commute_ok)
);

// File: tb/zvs_hcc_bench.sv
`timescale 1ns/1ps
module zvs_hcc_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [W-1:0] cur_meas = '0;
  logic signed [W-1:0] cur_set = '0;
  logic signed [W-1:0] cur_thr = '0;
  logic signed [W-1:0] cur_slope = '0;
  logic hs_diode_on = 1'b0;
  logic ls_diode_on = 1'b0;
  logic hs_gate, ls_gate;

  always #2 clk = ~clk;

  zvs_hcc #(.W(W)) u_zvs_hcc (
    .clk(clk), .rst_n(rst_n),
    .cur_meas(cur_meas), .cur_set(cur_set), .cur_thr(cur_thr), .cur_slope(cur_slope),
    .hs_diode_on(hs_diode_on), .ls_diode_on(ls_diode_on),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // Reference phase: 0 high on, 1 wait low diode, 2 low on, 3 wait high diode.
  int ref_ph = 1;

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic step(input int im, input int st, input int th_in, input int sl,
                      input bit dh, input bit dl, input string tag);
    int th, up, dn;
    @(negedge clk);
    cur_meas = W'(im); cur_set = W'(st); cur_thr = W'(th_in); cur_slope = W'(sl);
    hs_diode_on = dh; ls_diode_on = dl;
    th = (th_in < 0) ? 0 : th_in;
    up = (st >= 0) ? sat16(2 * st + th) : th;
    dn = (st >= 0) ? -th : sat16(2 * st - th);
    case (ref_ph)
      0: if (im >= th && (im >= up || sl <= 0)) ref_ph = 1;
      1: if (dl) ref_ph = 2;
      2: if (im <= -th && (im <= dn || sl >= 0)) ref_ph = 3;
      default: if (dh) ref_ph = 0;
    endcase
    exp_q.push_back({ref_ph == 0, ref_ph == 2});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares gates one time unit after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({hs_gate, ls_gate} !== e) begin
          n_fail++;
          $display("FAIL %s: gates hs/ls = %b%b, expected %b%b", t, hs_gate, ls_gate, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (hs_gate !== 1'b0 || ls_gate !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: gates hs/ls = %b%b, expected 00", hs_gate, ls_gate);
    end
    rst_n = 1'b1;

    step(0, 1000, 500, 0, 1, 0, "R1 R10 high diode ignored while waiting low");
    step(0, 1000, 500, 0, 0, 1, "R10 low on after low diode");
    step(-400, 1000, 500, -3, 0, 0, "R6 above lower level -thr");
    step(-500, 1000, 500, -3, 0, 0, "R6 at lower level -thr");
    step(-500, 1000, 500, -3, 0, 1, "R10 R11 low diode ignored while waiting high");
    step(0, 1000, 500, 3, 1, 0, "R10 high on after high diode");
    step(2499, 1000, 500, 3, 0, 0, "R5 below upper level");
    step(2500, 1000, 500, 3, 0, 0, "R2 R5 upper level 2*set+thr reached");
    step(2500, 1000, 500, 3, 0, 1, "R11 low on one clock after dead phase");
    step(-2499, -1000, 500, -3, 0, 0, "R3 above lower level 2*set-thr");
    step(-2500, -1000, 500, -3, 0, 0, "R3 at lower level 2*set-thr");
    step(0, -1000, 500, 0, 1, 0, "R10 high on");
    step(499, -1000, 500, 3, 0, 0, "R3 below upper level thr");
    step(500, -1000, 500, 3, 0, 0, "R3 at upper level thr");
    step(0, -1000, 500, 0, 0, 1, "R10 low on");
    step(-400, -1000, 500, 5, 0, 0, "R7 slope positive but current above -thr");
    step(-600, -1000, 500, -1, 0, 0, "R9 negative slope gives no forced turn-off");
    step(-600, -1000, 500, 0, 0, 0, "R9 zero slope forces low off");
    step(0, 1000, 500, 0, 1, 0, "R10 high on");
    step(600, 1000, 500, 1, 0, 0, "R8 positive slope gives no forced turn-off");
    step(400, 1000, 500, -5, 0, 0, "R7 slope negative but current below thr");
    step(600, 1000, 500, 0, 0, 0, "R8 zero slope forces high off");
    step(0, 1000, 500, 0, 0, 1, "R10 low on");
    step(-32767, -30000, 10000, -1, 0, 0, "R4 lower level saturates at -32768");
    step(-32768, -30000, 10000, -1, 0, 0, "R4 at saturated lower level");
    step(0, -30000, 10000, 0, 1, 0, "R10 high on");
    step(32766, 30000, 10000, 1, 0, 0, "R4 upper level saturates at 32767");
    step(32767, 30000, 10000, 1, 0, 0, "R4 at saturated upper level");
    step(0, 30000, 10000, 0, 0, 1, "R10 low on");
    step(1, 0, -100, -1, 0, 0, "R4 negative thr as zero, low stays");
    step(0, 0, -100, -1, 0, 0, "R4 negative thr as zero, low off at 0");
    step(0, 0, -100, 0, 1, 0, "R10 high on");
    step(-1, 0, -100, 1, 0, 0, "R4 negative thr as zero, high stays");
    step(0, 0, -100, 1, 0, 0, "R4 negative thr as zero, high off at 0");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): run still busy, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule